// File: doc/BRIEF.md
# Write-Back, Write-Around Direct-Mapped Word Cache

This block is a direct-mapped data cache placed between a processor request port and a slower memory that transfers one 32-bit word at a time. Each line holds a single word together with its tag, a valid bit and a dirty bit. Processor addresses are byte addresses, but every access moves one whole word, so the two lowest address bits never select anything. The line index is taken from the address bits just above the byte offset, and the tag is everything above the index.

Writes that hit update only the cached word and mark the line dirty. Writes that miss go straight to memory and leave every line untouched. A read miss fetches the word from memory and fills the line clean. If the line it replaces is valid and dirty, the old word is first written back to its own address. A small controller runs these memory transfers over a request/ready handshake and stalls the processor until the access retires. Five counters record read hits, read misses, write hits, write misses and writebacks.

The processor holds `cpu_req` and its operands until `cpu_ack` is high in a cycle. The access retires at the clock edge that ends that cycle. A hit retires in the same cycle it is presented.

Top module: `wbna_cache`

## Requirements
- R1: A read always returns the most recent value written to that word address, whatever mix of hits, misses and evictions came before (the same results a write-through, write-allocate cache would give).
- R2: The line index is address bits [log2(LINES)+1:2] and the tag is bits [ADDR_W-1:log2(LINES)+2]. Words with equal index and different tag displace each other; words with different index coexist.
- R3: A write hit retires in its first cycle without any memory transfer, updates the cached word and marks the line dirty.
- R4: A write miss makes exactly one memory write, to the word-aligned request address with the request data. It then retires and changes no cache line.
- R5: A read miss on a valid dirty line first writes the old word to memory at address {old tag, index, 2'b00}, then reads the requested word. The line is then clean.
- R6: A read miss on an invalid or clean line makes exactly one memory read of the word-aligned request address and no write.
- R7: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady from the start of a transfer until the cycle in which `mem_ready` is high. A transfer completes in that cycle.
- R8: `cpu_stall` is high in every cycle in which a presented access has not retired. It is low in a cycle with `cpu_ack` high, and low while no access is pending. A read hit retires in its first cycle.
- R9: Each retired access adds one to exactly one of the read-hit, read-miss, write-hit or write-miss counters. Each writeback adds one to the writeback counter.
- R10: After reset all lines are invalid, every counter is zero, and `cpu_stall`, `cpu_ack` and `mem_req` are low.
- R11: Address bits [1:0] are ignored. Accesses that differ only in those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor access present; held until retired |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ack` on a read |
| cpu_ack | output | 1 | Access retires at the end of this cycle |
| cpu_stall | output | 1 | Access pending and not retiring this cycle |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Current transfer completes this cycle |
| cnt_rd_hit | output | CNT_W | Read hits |
| cnt_rd_miss | output | CNT_W | Read misses |
| cnt_wr_hit | output | CNT_W | Write hits |
| cnt_wr_miss | output | CNT_W | Write misses |
| cnt_wback | output | CNT_W | Dirty writebacks |

## Verification
The bench builds the cache with 16 lines and limits traffic to a 64-word window, so four tags compete for every index. Small enough for exhaustive sweeps, this setup still makes every hit, clean miss, dirty eviction and write-around reachable within a few hundred accesses. Whole-window read, write and read sweeps are followed by a long pseudo-random mix with random byte offsets. Memory latencies from zero to three cycles are used, so exact retirement cycle counts, transfer order and writeback addresses can be predicted arithmetically for each access.

// File: rtl/wbna_pkg.sv
// Shared types for the write-back, write-around word cache.
// Assumes nothing beyond IEEE 1800-2017 packages.
package wbna_pkg;

    // Controller states: idle/lookup, victim writeback, word fetch, write-around.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FETCH = 2'd2,
        ST_WRMIS = 2'd3
    } ctrl_state_e;

    // Event slots feeding the counter bank.
    localparam int EV_RD_HIT  = 0;
    localparam int EV_RD_MISS = 1;
    localparam int EV_WR_HIT  = 2;
    localparam int EV_WR_MISS = 3;
    localparam int EV_WBACK   = 4;
    localparam int EV_COUNT   = 5;

endpackage

// File: rtl/wbna_tag_store.sv
// Tag, valid and dirty storage for a direct-mapped cache.
// One shared index per cycle. A fill sets the tag, sets valid and clears dirty.
// A mark sets dirty. Reads are combinational. Only valid/dirty are reset.
module wbna_tag_store #(
    parameter int LINES = 1024,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_dirty,
    output logic [TAG_W-1:0] line_tag,
    output logic             line_valid,
    output logic             line_dirty
);

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    // Tag array: written on fill only, never reset.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[idx] <= fill_tag;
    end

    // Valid and dirty flags: cleared by reset, set/cleared by fill and mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Combinational lookup of the selected line.
    always_comb begin
        line_tag   = tag_q[idx];
        line_valid = valid_q[idx];
        line_dirty = dirty_q[idx];
    end

endmodule

// File: rtl/wbna_data_store.sv
// Word data array, one word per line, combinational read, single write port.
// Contents are undefined until the line is filled.
module wbna_data_store #(
    parameter int LINES  = 1024,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] word_q [LINES];

    // Single write port shared by write hits and fills.
    always_ff @(posedge clk) begin
        if (wr_en) word_q[idx] <= wr_data;
    end

    // Combinational read of the selected line.
    assign rd_data = word_q[idx];

endmodule

// File: rtl/wbna_counters.sv
// Bank of event counters. Each counter adds one on its event pulse and wraps.
module wbna_counters #(
    parameter int N_EV  = 5,
    parameter int CNT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_EV-1:0]             ev,
    output logic [N_EV-1:0][CNT_W-1:0]  cnt
);

    for (genvar g = 0; g < N_EV; g++) begin : g_cnt
        logic [CNT_W-1:0] c_q;
        // One counter per event slot.
        always_ff @(posedge clk) begin
            if (!rst_n)     c_q <= '0;
            else if (ev[g]) c_q <= c_q + CNT_W'(1);
        end
        assign cnt[g] = c_q;
    end

endmodule

// File: rtl/wbna_ctrl.sv
// Miss-sequencing controller for the write-back, write-around cache.
// Looks up the presented word in ST_IDLE and retires hits in the same cycle.
// On a miss it latches the request and runs the memory transfers.
// Assumes the processor holds its request until cpu_ack and that the
// memory holds mem_ready high for exactly the completing cycle.
module wbna_ctrl
    import wbna_pkg::*;
#(
    parameter int WA_W   = 30,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [WA_W-1:0]     cpu_word,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [WA_W-1:0]     cur_word,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                cpu_ack,
    output logic                cpu_stall,
    input  logic                hit,
    input  logic                line_valid,
    input  logic                line_dirty,
    input  logic [WA_W-1:0]     victim_word,
    input  logic [DATA_W-1:0]   line_data,
    output logic                fill_en,
    output logic                mark_dirty,
    output logic                data_we,
    output logic [DATA_W-1:0]   data_wdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [WA_W-1:0]     mem_word,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                mem_ready,
    output logic [EV_COUNT-1:0] ev
);

    ctrl_state_e         state_q, state_d;
    logic [WA_W-1:0]     lat_word_q;
    logic [DATA_W-1:0]   lat_wdata_q;
    logic                idle_miss;

    assign idle_miss = (state_q == ST_IDLE) && cpu_req && !hit;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the missing request so the transfers do not depend on the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_word_q  <= '0;
            lat_wdata_q <= '0;
        end else if (idle_miss) begin
            lat_word_q  <= cpu_word;
            lat_wdata_q <= cpu_wdata;
        end
    end

    // Index source: live request when idle, latched request during a miss.
    assign cur_word = (state_q == ST_IDLE) ? cpu_word : lat_word_q;

    // Next state, handshakes, array controls and events.
    always_comb begin
        state_d    = state_q;
        cpu_ack    = 1'b0;
        cpu_stall  = 1'b0;
        cpu_rdata  = line_data;
        fill_en    = 1'b0;
        mark_dirty = 1'b0;
        data_we    = 1'b0;
        data_wdata = cpu_wdata;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_word   = lat_word_q;
        mem_wdata  = lat_wdata_q;
        ev         = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        cpu_ack = 1'b1;
                        if (cpu_we) begin
                            data_we        = 1'b1;
                            mark_dirty     = 1'b1;
                            ev[EV_WR_HIT]  = 1'b1;
                        end else begin
                            ev[EV_RD_HIT]  = 1'b1;
                        end
                    end else begin
                        cpu_stall = 1'b1;
                        if (cpu_we)                       state_d = ST_WRMIS;
                        else if (line_valid && line_dirty) state_d = ST_WBACK;
                        else                              state_d = ST_FETCH;
                    end
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_word  = victim_word;
                mem_wdata = line_data;
                cpu_stall = 1'b1;
                if (mem_ready) begin
                    ev[EV_WBACK] = 1'b1;
                    state_d      = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_req   = 1'b1;
                cpu_rdata = mem_rdata;
                if (mem_ready) begin
                    cpu_ack        = 1'b1;
                    fill_en        = 1'b1;
                    data_we        = 1'b1;
                    data_wdata     = mem_rdata;
                    ev[EV_RD_MISS] = 1'b1;
                    state_d        = ST_IDLE;
                end else begin
                    cpu_stall = 1'b1;
                end
            end
            ST_WRMIS: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready) begin
                    cpu_ack        = 1'b1;
                    ev[EV_WR_MISS] = 1'b1;
                    state_d        = ST_IDLE;
                end else begin
                    cpu_stall = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/wbna_cache.sv
// Top of the direct-mapped, one-word-per-line cache with write-back on
// read-miss eviction and write-around on write misses.
// LINES must be a power of two. Byte offset bits [1:0] are ignored.
module wbna_cache
    import wbna_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 1024,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [CNT_W-1:0]  cnt_rd_hit,
    output logic [CNT_W-1:0]  cnt_rd_miss,
    output logic [CNT_W-1:0]  cnt_wr_hit,
    output logic [CNT_W-1:0]  cnt_wr_miss,
    output logic [CNT_W-1:0]  cnt_wback
);

    localparam int IDX_W = $clog2(LINES);
    localparam int WA_W  = ADDR_W - 2;
    localparam int TAG_W = WA_W - IDX_W;

    logic [WA_W-1:0]     cur_word, victim_word, mem_word;
    logic [IDX_W-1:0]    idx;
    logic [TAG_W-1:0]    cur_tag, line_tag;
    logic                line_valid, line_dirty, hit;
    logic                fill_en, mark_dirty, data_we;
    logic [DATA_W-1:0]   line_data, data_wdata;
    logic [EV_COUNT-1:0] ev;
    logic [EV_COUNT-1:0][CNT_W-1:0] cnt;
    logic                unused_offset;

    assign unused_offset = ^cpu_addr[1:0];

    // Address split and hit compare.
    assign idx         = cur_word[IDX_W-1:0];
    assign cur_tag     = cur_word[WA_W-1:IDX_W];
    assign hit         = line_valid && (line_tag == cur_tag);
    assign victim_word = {line_tag, idx};
    assign mem_addr    = {mem_word, 2'b00};

    wbna_ctrl #(.WA_W(WA_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_word(cpu_addr[ADDR_W-1:2]), .cpu_wdata(cpu_wdata),
        .cur_word(cur_word), .cpu_rdata(cpu_rdata),
        .cpu_ack(cpu_ack), .cpu_stall(cpu_stall),
        .hit(hit), .line_valid(line_valid), .line_dirty(line_dirty),
        .victim_word(victim_word), .line_data(line_data),
        .fill_en(fill_en), .mark_dirty(mark_dirty),
        .data_we(data_we), .data_wdata(data_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .ev(ev)
    );

    wbna_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(idx),
        .fill_en(fill_en), .fill_tag(cur_tag), .mark_dirty(mark_dirty),
        .line_tag(line_tag), .line_valid(line_valid), .line_dirty(line_dirty)
    );

    wbna_data_store #(.LINES(LINES), .DATA_W(DATA_W)) u_data (
        .clk(clk), .idx(idx), .wr_en(data_we),
        .wr_data(data_wdata), .rd_data(line_data)
    );

    wbna_counters #(.N_EV(EV_COUNT), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ev(ev), .cnt(cnt)
    );

    assign cnt_rd_hit  = cnt[EV_RD_HIT];
    assign cnt_rd_miss = cnt[EV_RD_MISS];
    assign cnt_wr_hit  = cnt[EV_WR_HIT];
    assign cnt_wr_miss = cnt[EV_WR_MISS];
    assign cnt_wback   = cnt[EV_WBACK];

endmodule

// File: rtl/wbna_cache_chk.sv
// Protocol checker for wbna_cache, bound to every instance of the top.
// Watches ports only.
module wbna_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_ack,
    input logic              cpu_stall,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic [CNT_W-1:0]  cnt_rd_hit,
    input logic [CNT_W-1:0]  cnt_rd_miss,
    input logic [CNT_W-1:0]  cnt_wr_hit,
    input logic [CNT_W-1:0]  cnt_wr_miss
);

    // R7: an open transfer keeps its request and operands until ready.
    p_mem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)
            && $stable(mem_addr) && $stable(mem_wdata)));

    // R5: a write that completes without retiring is a writeback; a read follows.
    p_wb_then_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready && !cpu_ack) |=> (mem_req && !mem_we));

    // R8: a presented, non-retiring access stalls.
    p_stall_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ack) |-> cpu_stall);

    // R8: retiring and stalling are exclusive.
    p_ack_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> !cpu_stall);

    // R8: with nothing pending the memory port is quiet.
    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stall && !cpu_ack) |-> !mem_req);

    // R9: at most one access counter moves per cycle.
    p_one_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cnt_rd_hit != $past(cnt_rd_hit), cnt_rd_miss != $past(cnt_rd_miss),
                    cnt_wr_hit != $past(cnt_wr_hit), cnt_wr_miss != $past(cnt_wr_miss)}) <= 1);

    // R9: read counters move only after a retired read.
    p_rd_count_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_rd_hit != $past(cnt_rd_hit)) || (cnt_rd_miss != $past(cnt_rd_miss)))
            |-> $past(cpu_ack && !cpu_we));

    // R9: write counters move only after a retired write.
    p_wr_count_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_wr_hit != $past(cnt_wr_hit)) || (cnt_wr_miss != $past(cnt_wr_miss)))
            |-> $past(cpu_ack && cpu_we));

endmodule

bind wbna_cache wbna_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_ack(cpu_ack), .cpu_stall(cpu_stall), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss),
    .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss)
);

// File: tb/test_wbna_cache.sv
`timescale 1ns/1ps
// Self-checking bench: 16-line cache, 64-word window, latency 0..3.
module test_wbna_cache;

    localparam int LINES = 16;
    localparam int WORDS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ack, cpu_stall;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [31:0] c_rh, c_rm, c_wh, c_wm, c_wb;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    wbna_cache #(.ADDR_W(32), .DATA_W(32), .LINES(LINES), .CNT_W(32)) i_wbna_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ack(cpu_ack), .cpu_stall(cpu_stall), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .cnt_rd_hit(c_rh), .cnt_rd_miss(c_rm), .cnt_wr_hit(c_wh),
        .cnt_wr_miss(c_wm), .cnt_wback(c_wb)
    );

    // Memory model: ready after lat+1 request cycles, one-cycle pulse, transfer log.
    logic [31:0] mem_img [WORDS];
    int          lat = 0, wait_cnt = 0, xfer_total = 0;
    logic        log_we [4];
    int          log_word [4];
    logic [31:0] log_data [4];

    always @(posedge clk) begin
        if (mem_ready) begin
            mem_ready <= 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                wait_cnt  <= 0;
                mem_ready <= 1'b1;
                log_we[xfer_total % 4]   <= mem_we;
                log_word[xfer_total % 4] <= int'(mem_addr[7:2]);
                log_data[xfer_total % 4] <= mem_wdata;
                xfer_total <= xfer_total + 1;
                if (mem_we) mem_img[mem_addr[7:2]] <= mem_wdata;
                else        mem_rdata <= mem_img[mem_addr[7:2]];
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    // Reference state computed from the requirements.
    logic [31:0] ref_val [WORDS];
    logic [31:0] exp_mem [WORDS];
    bit          sh_v [LINES];
    bit          sh_d [LINES];
    int          sh_t [LINES];
    int          e_rh = 0, e_rm = 0, e_wh = 0, e_wm = 0, e_wb = 0;
    logic [31:0] rng = 32'h1234_5678;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic check_counts(input string req);
        chk(c_rh == e_rh, req, c_rh, e_rh);
        chk(c_rm == e_rm, req, c_rm, e_rm);
        chk(c_wh == e_wh, req, c_wh, e_wh);
        chk(c_wm == e_wm, req, c_wm, e_wm);
        chk(c_wb == e_wb, req, c_wb, e_wb);
    endtask

    task automatic check_memory(input string req);
        int bad = 0;
        for (int i = 0; i < WORDS; i++) if (mem_img[i] !== exp_mem[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    // One processor access with per-access checks and model update.
    task automatic access(input bit we, input int w, input int off, input logic [31:0] d);
        int  idx = w % LINES;
        int  tg = w / LINES;
        bit  hit = sh_v[idx] && (sh_t[idx] == tg);
        bit  dvic = !hit && sh_v[idx] && sh_d[idx];
        int  vic = sh_t[idx] * LINES + idx;
        int  base = xfer_total;
        int  cyc = 0;
        int  n, exp_cyc;
        bit  stall_bad = 0;
        logic [31:0] got = '0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = 32'(w * 4 + off); cpu_wdata = d;
        forever begin
            #1;
            cyc++;
            if (cpu_ack) begin
                if (cpu_stall) stall_bad = 1;
                got = cpu_rdata;
                break;
            end
            if (!cpu_stall) stall_bad = 1;
            if (cyc > 100) begin
                chk(0, "watchdog", cyc, 100);
                break;
            end
            @(negedge clk);
        end
        @(posedge clk);
        #1 cpu_req = 1'b0;
        n = xfer_total - base;
        chk(!stall_bad, "R8", stall_bad, 0);
        if (!we) chk(got === ref_val[w], "R1", got, ref_val[w]);
        if (hit) begin
            exp_cyc = 1;
            chk(n == 0, we ? "R3" : "R8", n, 0);
        end else if (we) begin
            exp_cyc = lat + 3;
            chk(n == 1 && log_we[base % 4] && log_word[base % 4] == w
                && log_data[base % 4] == d, "R4", n, 1);
        end else if (dvic) begin
            exp_cyc = 2 * lat + 5;
            chk(n == 2 && log_we[base % 4] && log_word[base % 4] == vic
                && log_data[base % 4] == ref_val[vic], "R5", log_word[base % 4], vic);
            chk(!log_we[(base + 1) % 4] && log_word[(base + 1) % 4] == w, "R5",
                log_word[(base + 1) % 4], w);
        end else begin
            exp_cyc = lat + 3;
            chk(n == 1 && !log_we[base % 4] && log_word[base % 4] == w, "R6", n, 1);
        end
        chk(cyc == exp_cyc, "R7", cyc, exp_cyc);
        // Model update.
        if (we) begin
            ref_val[w] = d;
            if (hit) begin sh_d[idx] = 1; e_wh++; end
            else begin exp_mem[w] = d; e_wm++; end
        end else if (hit) begin
            e_rh++;
        end else begin
            if (dvic) begin exp_mem[vic] = ref_val[vic]; e_wb++; end
            sh_v[idx] = 1; sh_d[idx] = 0; sh_t[idx] = tg; e_rm++;
        end
    endtask

    initial begin
        #(200000 * 8);
        chk(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int rh0, rm0;
        for (int i = 0; i < WORDS; i++) begin
            mem_img[i] = 32'hA000_0000 + 32'(i * 7);
            exp_mem[i] = mem_img[i];
            ref_val[i] = mem_img[i];
        end
        for (int i = 0; i < LINES; i++) begin sh_v[i] = 0; sh_d[i] = 0; sh_t[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state seen during reset and just after release.
        chk(!cpu_stall && !cpu_ack && !mem_req, "R10", {cpu_stall, cpu_ack, mem_req}, 0);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk(!cpu_stall && !cpu_ack && !mem_req, "R10", {cpu_stall, cpu_ack, mem_req}, 0);
        check_counts("R10");

        // Sweep 1: cold reads of the whole window (all misses after reset, R10/R6).
        lat = 0;
        for (int w = 0; w < WORDS; w++) access(0, w, 0, '0);
        chk(e_rm == WORDS, "R10", e_rm, WORDS);
        check_counts("R9");

        // R2: lines of tag 3 are resident; rereading them hits, other tags miss.
        rh0 = e_rh; rm0 = e_rm;
        for (int w = 48; w < 64; w++) access(0, w, 0, '0);
        chk(e_rh - rh0 == 16 && e_rm == rm0, "R2", e_rh - rh0, 16);
        for (int w = 0; w < 16; w++) access(0, w, 0, '0);
        chk(e_rm - rm0 == 16, "R2", e_rm - rm0, 16);
        check_counts("R2");

        // Sweep 2: write every word (tag 0 hits, others write around), lat 1.
        lat = 1;
        for (int w = 0; w < WORDS; w++) access(1, w, 0, 32'h5000_0000 + 32'(w));
        check_memory("R3");
        check_counts("R4");

        // Sweep 3: read every word again: dirty tag-0 lines are written back.
        lat = 2;
        for (int w = WORDS - 1; w >= 0; w--) access(0, w, 0, '0);
        check_memory("R5");
        check_counts("R9");

        // R11: byte offsets select the same word.
        lat = 0;
        access(0, 9, 3, '0);
        access(1, 9, 1, 32'hCAFE_F00D);
        access(0, 9, 2, '0);
        chk(ref_val[9] == 32'hCAFE_F00D, "R11", ref_val[9], 32'hCAFE_F00D);

        // Random mix: all kinds of access, random offsets and latencies.
        for (int k = 0; k < 3000; k++) begin
            rng = nxt(rng);
            lat = int'(rng[25:24]);
            access(rng[0] & rng[1], int'(rng[7:2]), int'(rng[9:8]), nxt(rng));
        end
        check_counts("R9");
        check_memory("R1");

        @(negedge clk);
        #1;
        chk(!cpu_stall && !mem_req, "R8", {cpu_stall, mem_req}, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule